// File: doc/BRIEF.md
# Program Sequencer with Hardware Call Stack

This block produces the fetch address for a small DSP core. It holds the program counter and, on each enabled step, picks the next address. The next address is one of four things: the following instruction, a resolved target address, the entry on top of a dedicated return-address stack, or the current address again. The choice is made by a decoded control-transfer opcode.

Subroutine calls and returns go only through the internal stack. Nothing else can read or write that stack. Conditional branches carry no condition-code state. Each branch compares its own signed operand with zero, using one of six relations, and jumps to the target when the relation holds.

A halt opcode freezes the sequencer until a synchronous reset. Overflow and underflow of the stack raise sticky flags.

Top module: `prog_sequencer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets `pc` to 0, empties the call stack, and clears `halted`, `stack_ovf` and `stack_unf`.
- R2: Opcode 0 (sequential) advances `pc` by one, wrapping modulo 2^ADDR_W. Opcodes 11 to 15 are unassigned and behave exactly like opcode 0.
- R3: While `step` is low, no opcode has any effect: `pc`, the stack and all flags keep their values.
- R4: Opcode 1 (jump) loads `target` into `pc` on the next edge.
- R5: Opcode 2 (call) pushes `pc`+1 (modulo 2^ADDR_W) onto the call stack and loads `target` into `pc`.
- R6: Opcode 3 (return) pops the top stack entry and loads it into `pc`.
- R7: Opcodes 5 to 10 are branches. They test `operand` as a signed two's-complement value against zero: 5 equal, 6 not equal, 7 greater, 8 less, 9 greater-or-equal, 10 less-or-equal. A taken branch loads `target`. A branch that is not taken advances `pc` by one.
- R8: Opcode 4 (halt) sets `halted` and leaves `pc` unchanged. While halted, `pc`, the stack and the flags stay frozen whatever the inputs, until reset.
- R9: A call while the stack holds DEPTH entries discards the push and sets the sticky `stack_ovf`. Control still goes to `target`.
- R10: A return with an empty stack sets the sticky `stack_unf` and leaves `pc` unchanged.
- R11: The stack is last-in first-out for up to DEPTH nested calls: returns come back in the reverse order of the calls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Advances the sequencer by one instruction |
| op_code | input | 4 | Decoded control-transfer opcode |
| target | input | ADDR_W | Resolved jump, call or branch target |
| operand | input | DATA_W | Signed value compared with zero by branches |
| pc | output | ADDR_W | Current program counter |
| halted | output | 1 | Sequencer stopped by halt |
| stack_ovf | output | 1 | Sticky: a call found the stack full |
| stack_unf | output | 1 | Sticky: a return found the stack empty |

## Verification
The bench builds the sequencer with ADDR_W=6 and DEPTH=4, and keeps DATA_W at 16. The narrow address lets counter wrap-around occur within a few dozen steps. The shallow stack reaches overflow after four nested calls, and a full unwind then reaches underflow. With the 16-bit operand, branches can be exercised at the most negative and most positive values as well as around zero. A long random stretch then mixes calls, returns and branches, so that full and empty stack states are entered from many different histories.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [3:0] {
        OP_NEXT = 4'd0,
        OP_JUMP = 4'd1,
        OP_CALL = 4'd2,
        OP_RET  = 4'd3,
        OP_HALT = 4'd4,
        OP_BEQ  = 4'd5,
        OP_BNE  = 4'd6,
        OP_BGT  = 4'd7,
        OP_BLT  = 4'd8,
        OP_BGE  = 4'd9,
        OP_BLE  = 4'd10
    } seq_op_e;

    typedef enum logic [2:0] {
        REL_EQ = 3'd0,
        REL_NE = 3'd1,
        REL_GT = 3'd2,
        REL_LT = 3'd3,
        REL_GE = 3'd4,
        REL_LE = 3'd5
    } rel_e;

    typedef enum logic [1:0] {
        SRC_INC    = 2'd0,
        SRC_TARGET = 2'd1,
        SRC_TOP    = 2'd2,
        SRC_HOLD   = 2'd3
    } pc_src_e;

    typedef struct packed {
        pc_src_e src;
        logic    push;
        logic    pop;
        logic    halt_set;
        logic    ovf_set;
        logic    unf_set;
    } seq_ctrl_s;

    function automatic logic is_branch(input logic [3:0] op);
        return (op >= 4'(OP_BEQ)) && (op <= 4'(OP_BLE));
    endfunction

    function automatic rel_e rel_of(input logic [3:0] op);
        logic [3:0] d;
        d = op - 4'(OP_BEQ);
        return rel_e'(d[2:0]);
    endfunction

endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
    import seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rel_e              rel,
    input  logic [DATA_W-1:0] operand,
    output logic              taken
);
    logic neg;
    logic zero;

    assign neg  = operand[DATA_W-1];
    assign zero = (operand == '0);

    always_comb begin
        unique case (rel)
            REL_EQ:  taken = zero;
            REL_NE:  taken = !zero;
            REL_GT:  taken = !neg && !zero;
            REL_LT:  taken = neg;
            REL_GE:  taken = !neg;
            REL_LE:  taken = neg || zero;
            default: taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  logic [3:0] op_code,
    input  logic       step,
    input  logic       halted,
    input  logic       taken,
    input  logic       stk_full,
    input  logic       stk_empty,
    output seq_ctrl_s  ctrl
);
    always_comb begin
        ctrl = '{src: SRC_INC, push: 1'b0, pop: 1'b0,
                 halt_set: 1'b0, ovf_set: 1'b0, unf_set: 1'b0};
        if (!step || halted) begin
            ctrl.src = SRC_HOLD;
        end else if (is_branch(op_code)) begin
            ctrl.src = taken ? SRC_TARGET : SRC_INC;
        end else begin
            case (op_code)
                4'(OP_JUMP): ctrl.src = SRC_TARGET;
                4'(OP_CALL): begin
                    ctrl.src = SRC_TARGET;
                    if (stk_full) ctrl.ovf_set = 1'b1;
                    else          ctrl.push    = 1'b1;
                end
                4'(OP_RET): begin
                    if (stk_empty) begin
                        ctrl.src     = SRC_HOLD;
                        ctrl.unf_set = 1'b1;
                    end else begin
                        ctrl.src = SRC_TOP;
                        ctrl.pop = 1'b1;
                    end
                end
                4'(OP_HALT): begin
                    ctrl.src      = SRC_HOLD;
                    ctrl.halt_set = 1'b1;
                end
                default: ctrl.src = SRC_INC;
            endcase
        end
    end
endmodule

// File: rtl/seq_call_stack.sv
module seq_call_stack #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [ADDR_W-1:0] push_data,
    output logic [ADDR_W-1:0] top,
    output logic              full,
    output logic              empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ADDR_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_m1;
    logic [IDX_W-1:0]  rd_idx;

    assign full   = (cnt == FULL_CNT);
    assign empty  = (cnt == '0);
    assign cnt_m1 = cnt - 1'b1;
    assign rd_idx = IDX_W'(cnt_m1);
    assign top    = mem[rd_idx];

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && !full && cnt == CNT_W'(i)) mem[i] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (push && !full) begin
            cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            cnt <= cnt_m1;
        end
    end

    // R11
    depth_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL_CNT);

    // R5
    push_grow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> cnt == $past(cnt) + 1'b1);

    // R6
    pop_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !empty) |=> cnt == $past(cnt) - 1'b1);

    // R5
    excl_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(push && pop));
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
    import seq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [3:0]        op_code,
    input  logic [ADDR_W-1:0] target,
    input  logic [DATA_W-1:0] operand,
    output logic [ADDR_W-1:0] pc,
    output logic              halted,
    output logic              stack_ovf,
    output logic              stack_unf
);
    logic [ADDR_W-1:0] pc_inc;
    logic [ADDR_W-1:0] stk_top;
    logic              stk_full;
    logic              stk_empty;
    logic              taken;
    rel_e              rel;
    seq_ctrl_s         ctrl;

    assign pc_inc = pc + 1'b1;
    assign rel    = rel_of(op_code);

    seq_cond_eval #(.DATA_W(DATA_W)) u_cond (
        .rel     (rel),
        .operand (operand),
        .taken   (taken)
    );

    seq_decode u_dec (
        .op_code   (op_code),
        .step      (step),
        .halted    (halted),
        .taken     (taken),
        .stk_full  (stk_full),
        .stk_empty (stk_empty),
        .ctrl      (ctrl)
    );

    seq_call_stack #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_stk (
        .clk       (clk),
        .rst       (rst),
        .push      (ctrl.push),
        .pop       (ctrl.pop),
        .push_data (pc_inc),
        .top       (stk_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            halted    <= 1'b0;
            stack_ovf <= 1'b0;
            stack_unf <= 1'b0;
        end else begin
            unique case (ctrl.src)
                SRC_INC:    pc <= pc_inc;
                SRC_TARGET: pc <= target;
                SRC_TOP:    pc <= stk_top;
                default:    pc <= pc;
            endcase
            halted    <= halted    | ctrl.halt_set;
            stack_ovf <= stack_ovf | ctrl.ovf_set;
            stack_unf <= stack_unf | ctrl.unf_set;
        end
    end

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && $stable(pc) && $stable(stack_ovf) && $stable(stack_unf));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc) && $stable(halted));

    // R4
    jump_load_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !halted && op_code == 4'(OP_JUMP)) |=> pc == $past(target));

    // R9
    ovf_call_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !halted && op_code == 4'(OP_CALL) && stk_full)
            |=> stack_ovf && pc == $past(target));

    // R10
    unf_ret_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !halted && op_code == 4'(OP_RET) && stk_empty)
            |=> stack_unf && pc == $past(pc));

    // R7
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !halted && op_code == 4'(OP_BEQ) && operand != '0)
            |=> pc == $past(pc) + 1'b1);
endmodule

// File: tb/tb_prog_sequencer.sv
module tb_prog_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEP   = 4;
    localparam int PCMOD = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          step = 1'b0;
    logic [3:0]    op_code = 4'd0;
    logic [AW-1:0] target = '0;
    logic [DW-1:0] operand = '0;
    logic [AW-1:0] pc;
    logic          halted;
    logic          stack_ovf;
    logic          stack_unf;

    int errors = 0;
    int checks = 0;

    int m_pc = 0;
    int m_stk[$];
    bit m_halt = 0, m_ovf = 0, m_unf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_sequencer #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEP)) dut (
        .clk(clk), .rst(rst), .step(step), .op_code(op_code),
        .target(target), .operand(operand), .pc(pc), .halted(halted),
        .stack_ovf(stack_ovf), .stack_unf(stack_unf)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int o);
        case (o)
            1: return "R4";
            2: return "R5";
            3: return "R6";
            4: return "R8";
            5, 6, 7, 8, 9, 10: return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic cyc(input bit r, input bit s, input int o, input int t, input int d, input string tag);
        bit tk;
        shortint sd;
        @(negedge clk);
        rst = r; step = s; op_code = 4'(o); target = AW'(t); operand = DW'(d);
        t = t % PCMOD;
        sd = shortint'(d);
        if (r) begin
            m_pc = 0; m_stk.delete(); m_halt = 0; m_ovf = 0; m_unf = 0;
        end else if (s && !m_halt) begin
            case (o)
                1: m_pc = t;
                2: begin
                    if (m_stk.size() == DEP) m_ovf = 1;
                    else m_stk.push_back((m_pc + 1) % PCMOD);
                    m_pc = t;
                end
                3: begin
                    if (m_stk.size() == 0) m_unf = 1;
                    else m_pc = m_stk.pop_back();
                end
                4: m_halt = 1;
                5, 6, 7, 8, 9, 10: begin
                    case (o)
                        5: tk = (sd == 0);
                        6: tk = (sd != 0);
                        7: tk = (sd > 0);
                        8: tk = (sd < 0);
                        9: tk = (sd >= 0);
                        default: tk = (sd <= 0);
                    endcase
                    m_pc = tk ? t : (m_pc + 1) % PCMOD;
                end
                default: m_pc = (m_pc + 1) % PCMOD;
            endcase
        end
        @(posedge clk); #1;
        check(tag, "pc", int'(pc), m_pc);
        check(tag, "halted", int'(halted), int'(m_halt));
        check(tag, "ovf", int'(stack_ovf), int'(m_ovf));
        check(tag, "unf", int'(stack_unf), int'(m_unf));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int opnds[5] = '{-32768, -1, 0, 1, 32767};
        // R1 reset state
        cyc(1, 0, 0, 0, 0, "R1");
        cyc(1, 1, 1, 17, 0, "R1");
        // R2 sequential advance
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0, 0, "R2");
        // R3 step low: nothing moves, including halt/call/ret opcodes
        for (int o = 0; o < 5; o++) cyc(0, 0, o, 33, 0, "R3");
        // R4 jump then R2 wrap at 2^ADDR_W
        cyc(0, 1, 1, 60, 0, "R4");
        for (int i = 0; i < 6; i++) cyc(0, 1, 0, 0, 0, "R2");
        // R2 unassigned opcodes act as sequential
        for (int o = 11; o < 16; o++) cyc(0, 1, o, 50, 0, "R2");
        // R7 six relations across signed extremes and zero
        for (int o = 5; o <= 10; o++)
            for (int k = 0; k < 5; k++)
                cyc(0, 1, o, (o * 7 + k * 3) % PCMOD, opnds[k], "R7");
        // R5 nested calls up to DEPTH
        cyc(0, 1, 1, 0, 0, "R4");
        for (int i = 0; i < DEP; i++) cyc(0, 1, 2, 10 * (i + 1), 0, "R5");
        // R9 call on full stack
        cyc(0, 1, 2, 55, 0, "R9");
        cyc(0, 1, 0, 0, 0, "R9");
        // R11 unwind in reverse order
        for (int i = 0; i < DEP; i++) cyc(0, 1, 3, 0, 0, "R11");
        // R10 return on empty stack, flag stays set
        cyc(0, 1, 3, 0, 0, "R10");
        cyc(0, 1, 0, 0, 0, "R10");
        cyc(0, 1, 3, 0, 0, "R10");
        // R6 single call/return
        cyc(1, 0, 0, 0, 0, "R1");
        cyc(0, 1, 0, 0, 0, "R2");
        cyc(0, 1, 2, 40, 0, "R5");
        cyc(0, 1, 0, 0, 0, "R2");
        cyc(0, 1, 3, 0, 0, "R6");
        // mixed random traffic without halt
        for (int i = 0; i < 600; i++) begin
            int o = $urandom_range(0, 15);
            int dsel = $urandom_range(0, 4);
            if (o == 4) o = 3;
            cyc(0, ($urandom_range(0, 7) != 0), o, $urandom_range(0, PCMOD - 1),
                opnds[dsel], tag_of(o));
        end
        // R8 halt freezes everything
        cyc(1, 0, 0, 0, 0, "R1");
        cyc(0, 1, 2, 20, 0, "R5");
        cyc(0, 1, 4, 9, 0, "R8");
        for (int o = 0; o < 16; o++) cyc(0, 1, o, 30, 0, "R8");
        cyc(0, 1, 3, 0, 0, "R8");
        // R1 reset releases halt
        cyc(1, 1, 4, 0, 0, "R1");
        cyc(0, 1, 0, 0, 0, "R2");
        cyc(0, 1, 3, 0, 0, "R10");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule